// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block drives the scan timing of a parallel RGB TFT panel from a single fast clock. It derives a pixel clock with a fractional divider that has four fraction bits, steps a horizontal and a vertical position counter once per pixel period, and decodes horizontal sync, vertical sync and a data-enable window from them. It also reports the current x and y coordinates inside the visible window. Each timing output passes through its own polarity inversion, selected by a mask input, so the same block fits panels with active-low or active-high strobes.

All timing is programmed through a simple write port. Every length is written as its value minus one. A write lands in a shadow copy, and the running timing takes the shadow copy only at the boundary between two frames, so no frame ever changes shape partway through. While the enable bit is clear, the counters stay at zero and every strobe sits at its inactive level.

Top module: `tft_timing_gen`

## Requirements
- R1: After a synchronous active-low reset, every timing output is inactive. With a mask of zero, hsync_o, vsync_o, de_o and pclk_o are all 0, and x_o and y_o are 0.
- R2: Address 0 is the horizontal word: sync width minus one in bits [31:26], line total minus one in bits [25:16]. One line spans total pixel periods. hsync is active for the first sync-width pixels of each line.
- R3: Address 1 is the vertical word: sync width minus one (in lines) in bits [31:26], frame total minus one (in lines) in bits [25:16]. One frame spans total lines. vsync is active for the first sync-width lines.
- R4: Address 4 is the clock word: fraction in [3:0], integer part in [15:4], high time minus one in [31:22]. Any 16 consecutive pixel periods last exactly integer×16+fraction fast cycles. pclk is active for the first high+1 cycles of each period.
- R5: Address 2 holds the window start (horizontal in [25:16], vertical in [9:0]). Address 3 holds the window size (width in [25:16], height in [9:0]). de is active only inside that window, so a frame carries width×height enabled pixels. x_o and y_o give the offset from the window start while de is active, and are 0 otherwise.
- R6: Writes to addresses 0 to 4 during an enabled frame do not change that frame's timing. They take effect from the first pixel of the next frame.
- R7: Address 5 bit 0 is the enable. While it is clear, the counters hold at zero and every output is inactive. Clearing it mid-frame makes the outputs inactive one cycle after the write.
- R8: pol_mask inverts each output's active level: bit 3 vsync, bit 2 hsync, bit 1 data-enable, bit 0 pixel clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 to 5) |
| cfg_wdata | input | 32 | Register write data |
| pol_mask | input | 4 | Per-output polarity inversion |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel clock |
| x_o | output | 10 | Column inside the active window |
| y_o | output | 10 | Row inside the active window |

## Verification
The block runs with one timing set and fraction 4, then a second set with a longer line and a zero fraction is written mid-frame. The first set shows whether the fractional carry adds its extra cycles. The mid-frame write shows whether the shadow copy is held back until the frame boundary, because the current frame's line period must stay unchanged. Running the same timing with the mask fully inverted separates the polarity handling from the counting logic. Clearing the enable mid-frame checks that the outputs fall back to idle at once.

// File: rtl/tft_timing_pkg.sv
// Package: field widths, register addresses and the decoded timing set
// shared by the timing generator modules.
package tft_timing_pkg;
    localparam int CNT_W  = 10;  // position counter / line field width
    localparam int SW_W   = 6;   // sync width field
    localparam int DIV_IW = 12;  // divider integer part
    localparam int FRAC_W = 4;   // divider fraction
    localparam int HI_W   = 10;  // pixel clock high time field

    localparam logic [2:0] ADDR_HOR  = 3'd0;
    localparam logic [2:0] ADDR_VER  = 3'd1;
    localparam logic [2:0] ADDR_POS  = 3'd2;
    localparam logic [2:0] ADDR_SIZE = 3'd3;
    localparam logic [2:0] ADDR_CLK  = 3'd4;
    localparam logic [2:0] ADDR_CTRL = 3'd5;

    typedef struct packed {
        logic [SW_W-1:0]   hsw_m1;
        logic [CNT_W-1:0]  htot_m1;
        logic [SW_W-1:0]   vsw_m1;
        logic [CNT_W-1:0]  vtot_m1;
        logic [CNT_W-1:0]  hstart;
        logic [CNT_W-1:0]  vstart;
        logic [CNT_W-1:0]  width;
        logic [CNT_W-1:0]  height;
        logic [DIV_IW-1:0] div_int;
        logic [FRAC_W-1:0] div_frac;
        logic [HI_W-1:0]   high_m1;
    } tim_cfg_t;
endpackage

// File: rtl/tft_cfg_regs.sv
// Configuration store. Holds a shadow timing set written by the port and an
// active set that the generator uses. Assumes the active set may only change
// while disabled or on the frame-wrap pulse from the scan counters.
module tft_cfg_regs
    import tft_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic        frame_wrap,
    output tim_cfg_t    act,
    output logic        en_q
);
    tim_cfg_t shadow;

    // Shadow set: decode writes into fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_HOR: begin
                    shadow.hsw_m1  <= wdata[31:26];
                    shadow.htot_m1 <= wdata[16 +: CNT_W];
                end
                ADDR_VER: begin
                    shadow.vsw_m1  <= wdata[31:26];
                    shadow.vtot_m1 <= wdata[16 +: CNT_W];
                end
                ADDR_POS: begin
                    shadow.hstart <= wdata[16 +: CNT_W];
                    shadow.vstart <= wdata[0 +: CNT_W];
                end
                ADDR_SIZE: begin
                    shadow.width  <= wdata[16 +: CNT_W];
                    shadow.height <= wdata[0 +: CNT_W];
                end
                ADDR_CLK: begin
                    shadow.div_frac <= wdata[0 +: FRAC_W];
                    shadow.div_int  <= wdata[FRAC_W +: DIV_IW];
                    shadow.high_m1  <= wdata[22 +: HI_W];
                end
                default: ;
            endcase
        end
    end

    // Enable bit: takes effect immediately, not frame-aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en && addr == ADDR_CTRL)
            en_q <= wdata[0];
    end

    // Active set: follows shadow while idle, else only at frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else if (!en_q || frame_wrap)
            act <= shadow;
    end
endmodule

// File: rtl/tft_frac_div.sv
// Fractional pixel clock divider. Each period lasts div_int fast cycles plus
// one extra when the 4-bit fraction accumulator carries. Assumes div_int >= 2
// when enabled; the clock is high for high_m1+1 cycles at the start of each period.
module tft_frac_div
    import tft_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_IW-1:0] div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [HI_W-1:0]   high_m1,
    output logic              pix_tick,
    output logic              pclk_raw
);
    localparam int LIM_W = DIV_IW + 1;

    logic [DIV_IW-1:0] cnt;
    logic [FRAC_W-1:0] acc;
    logic              carry;
    logic [LIM_W-1:0]  last_idx;
    logic [FRAC_W:0]   acc_sum;

    // Index of the final cycle of the current period.
    always_comb begin
        last_idx = {1'b0, div_int} + LIM_W'(carry) - LIM_W'(1);
        acc_sum  = {1'b0, acc} + {1'b0, div_frac};
    end

    assign pix_tick = en && ({1'b0, cnt} == last_idx);
    assign pclk_raw = en && (cnt <= DIV_IW'(high_m1));

    // Period counter and fraction accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            acc   <= '0;
            carry <= 1'b0;
        end else if (pix_tick) begin
            cnt   <= '0;
            acc   <= acc_sum[FRAC_W-1:0];
            carry <= acc_sum[FRAC_W];
        end else begin
            cnt <= cnt + DIV_IW'(1);
        end
    end
endmodule

// File: rtl/tft_scan_counter.sv
// Horizontal/vertical position counters and strobe decode. Advances one
// position per pixel tick; assumes the active window fits inside the totals.
module tft_scan_counter
    import tft_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pix_tick,
    input  tim_cfg_t         act,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             frame_wrap,
    output logic             hs_raw,
    output logic             vs_raw,
    output logic             de_raw,
    output logic [CNT_W-1:0] x_pos,
    output logic [CNT_W-1:0] y_pos
);
    logic           h_last;
    logic           v_last;
    logic           in_h;
    logic           in_v;
    logic [CNT_W:0] h_end;
    logic [CNT_W:0] v_end;

    // End-of-line / end-of-frame detection.
    always_comb begin
        h_last     = (h_cnt == act.htot_m1);
        v_last     = (v_cnt == act.vtot_m1);
        frame_wrap = pix_tick && h_last && v_last;
    end

    // Position counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (pix_tick) begin
            if (h_last) begin
                h_cnt <= '0;
                v_cnt <= v_last ? '0 : v_cnt + CNT_W'(1);
            end else begin
                h_cnt <= h_cnt + CNT_W'(1);
            end
        end
    end

    // Strobe and window decode.
    always_comb begin
        h_end  = {1'b0, act.hstart} + {1'b0, act.width};
        v_end  = {1'b0, act.vstart} + {1'b0, act.height};
        in_h   = (h_cnt >= act.hstart) && ({1'b0, h_cnt} < h_end);
        in_v   = (v_cnt >= act.vstart) && ({1'b0, v_cnt} < v_end);
        hs_raw = en && (h_cnt <= CNT_W'(act.hsw_m1));
        vs_raw = en && (v_cnt <= CNT_W'(act.vsw_m1));
        de_raw = en && in_h && in_v;
        x_pos  = de_raw ? h_cnt - act.hstart : '0;
        y_pos  = de_raw ? v_cnt - act.vstart : '0;
    end
endmodule

// File: rtl/tft_timing_gen.sv
// Top: programmable TFT timing generator. Ties configuration store, pixel
// clock divider and scan counters together and applies output polarity.
module tft_timing_gen
    import tft_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic [3:0]       pol_mask,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             pclk_o,
    output logic [CNT_W-1:0] x_o,
    output logic [CNT_W-1:0] y_o
);
    localparam int N_STROBE = 4;

    tim_cfg_t         act;
    logic             en_q;
    logic             pix_tick;
    logic             pclk_raw;
    logic             frame_wrap;
    logic             hs_raw;
    logic             vs_raw;
    logic             de_raw;
    logic [CNT_W-1:0] h_cnt;
    logic [CNT_W-1:0] v_cnt;
    logic [N_STROBE-1:0] raw_v;
    logic [N_STROBE-1:0] out_v;

    tft_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .frame_wrap (frame_wrap),
        .act        (act),
        .en_q       (en_q)
    );

    tft_frac_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .div_int  (act.div_int),
        .div_frac (act.div_frac),
        .high_m1  (act.high_m1),
        .pix_tick (pix_tick),
        .pclk_raw (pclk_raw)
    );

    tft_scan_counter u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .pix_tick   (pix_tick),
        .act        (act),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .frame_wrap (frame_wrap),
        .hs_raw     (hs_raw),
        .vs_raw     (vs_raw),
        .de_raw     (de_raw),
        .x_pos      (x_o),
        .y_pos      (y_o)
    );

    assign raw_v = {vs_raw, hs_raw, de_raw, pclk_raw};

    // Per-strobe polarity inversion.
    for (genvar i = 0; i < N_STROBE; i++) begin : g_pol
        assign out_v[i] = raw_v[i] ^ pol_mask[i];
    end

    assign vsync_o = out_v[3];
    assign hsync_o = out_v[2];
    assign de_o    = out_v[1];
    assign pclk_o  = out_v[0];
endmodule

// File: rtl/tft_timing_chk.sv
// Checker for the timing generator, attached to the top by bind.
module tft_timing_chk
    import tft_timing_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             pix_tick,
    input logic             frame_wrap,
    input logic             de_raw,
    input logic [CNT_W-1:0] h_cnt,
    input tim_cfg_t         act,
    input logic [3:0]       pol_mask,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             de_o,
    input logic             pclk_o,
    input logic [CNT_W-1:0] x_o,
    input logic [CNT_W-1:0] y_o
);
    // R7: idle means every strobe at its inactive level
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (vsync_o == pol_mask[3] && hsync_o == pol_mask[2] &&
                   de_o == pol_mask[1] && pclk_o == pol_mask[0]));

    // R5: coordinates are zero outside the window
    p_coord_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !de_raw |-> (x_o == '0 && y_o == '0));

    // R5: inside a run of enabled pixels x holds or steps by one
    p_x_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (de_raw && $past(de_raw) && en_q && $past(en_q)) |->
        (x_o == $past(x_o) || x_o == $past(x_o) + CNT_W'(1)));

    // R6: while running, the active set changes only after a frame wrap
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && act != $past(act)) |-> $past(frame_wrap));

    // R2: the column counter moves only on a pixel tick
    p_pos_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$past(pix_tick)) |-> $stable(h_cnt));
endmodule

bind tft_timing_gen tft_timing_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .pix_tick   (pix_tick),
    .frame_wrap (frame_wrap),
    .de_raw     (de_raw),
    .h_cnt      (h_cnt),
    .act        (act),
    .pol_mask   (pol_mask),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .de_o       (de_o),
    .pclk_o     (pclk_o),
    .x_o        (x_o),
    .y_o        (y_o)
);

// File: tb/tft_timing_gen_tb_top.sv
// Bench: behavioural per-cycle reference model plus period measurements.
module tft_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  pol_mask = '0;
    logic        hsync_o, vsync_o, de_o, pclk_o;
    logic [9:0]  x_o, y_o;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    tft_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pol_mask(pol_mask), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o), .x_o(x_o), .y_o(y_o)
    );

    // Reference model state
    logic [31:0] m_sh [0:4];
    logic [31:0] m_ac [0:4];
    int m_en, m_cnt, m_acc, m_carry, m_h, m_v;

    always @(posedge clk) begin
        int tick, wrap, lim, nxt;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
            m_en = 0; m_cnt = 0; m_acc = 0; m_carry = 0; m_h = 0; m_v = 0;
        end else begin
            lim  = (int'(m_ac[4][15:4]) + m_carry - 1) & 13'h1fff;
            tick = (m_en != 0) && (m_cnt == lim);
            wrap = tick && (m_h == int'(m_ac[0][25:16])) && (m_v == int'(m_ac[1][25:16]));
            if (m_en == 0) begin
                m_cnt = 0; m_acc = 0; m_carry = 0; m_h = 0; m_v = 0;
            end else if (tick) begin
                m_cnt = 0;
                nxt = m_acc + int'(m_ac[4][3:0]);
                m_acc = nxt % 16; m_carry = nxt / 16;
                if (m_h == int'(m_ac[0][25:16])) begin
                    m_h = 0;
                    m_v = (m_v == int'(m_ac[1][25:16])) ? 0 : m_v + 1;
                end else m_h = m_h + 1;
            end else m_cnt = (m_cnt + 1) % 4096;
            if (m_en == 0 || wrap)
                for (int i = 0; i < 5; i++) m_ac[i] = m_sh[i];
            if (cfg_wr_en && cfg_addr < 5) m_sh[cfg_addr] = cfg_wdata;
            if (cfg_wr_en && cfg_addr == 5) m_en = int'(cfg_wdata[0]);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    // Previous active levels for edge detection
    bit p_pclk, p_hs, p_vs;
    bit r_pclk, r_hs, r_vs;

    task automatic cyc();
        int hs, hw, de, x, y, ee;
        @(negedge clk);
        ee = m_en;
        hs = int'(m_ac[2][25:16]); hw = int'(m_ac[3][25:16]);
        de = ee && m_h >= hs && m_h < hs + hw &&
             m_v >= int'(m_ac[2][9:0]) && m_v < int'(m_ac[2][9:0]) + int'(m_ac[3][9:0]);
        x = de ? m_h - hs : 0;
        y = de ? m_v - int'(m_ac[2][9:0]) : 0;
        if (rst_n) begin
            check(hsync_o == ((ee && m_h <= int'(m_ac[0][31:26])) ^ pol_mask[2]), "R2 hsync", hsync_o, 0);
            check(vsync_o == ((ee && m_v <= int'(m_ac[1][31:26])) ^ pol_mask[3]), "R3 vsync", vsync_o, 0);
            check(pclk_o == ((ee && m_cnt <= int'(m_ac[4][31:22])) ^ pol_mask[0]), "R4 pclk", pclk_o, 0);
            check(de_o == (de[0] ^ pol_mask[1]), "R5 de", de_o, de);
            check(int'(x_o) == x, "R5 x", x_o, x);
            check(int'(y_o) == y, "R5 y", y_o, y);
        end
        r_pclk = (pclk_o ^ pol_mask[0]) && !p_pclk;
        r_hs   = (hsync_o ^ pol_mask[2]) && !p_hs;
        r_vs   = (vsync_o ^ pol_mask[3]) && !p_vs;
        p_pclk = pclk_o ^ pol_mask[0];
        p_hs   = hsync_o ^ pol_mask[2];
        p_vs   = vsync_o ^ pol_mask[3];
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc();
        cfg_wr_en = 1'b0;
    endtask

    // Measures one whole frame: pixels per line, lines per frame,
    // enabled pixels, and fast cycles per 16 pixel periods.
    task automatic measure(input int e_line, input int e_lines, input int e_de, input int e_16);
        int guard, line_pix, lines, de_pix, per_cyc, per_rises, hs_seen;
        bit line_done;
        guard = 0;
        do begin cyc(); guard++; end while (!r_vs && guard < 5000);
        line_pix = 0; lines = 0; de_pix = 0; per_cyc = 0; per_rises = 0;
        line_done = 0; hs_seen = 0;
        do begin
            cyc(); guard++;
            if (per_rises < 16) begin per_cyc++; if (r_pclk) per_rises++; end
            if (r_pclk && !line_done) line_pix++;
            if (r_hs) begin lines++; line_done = 1; end
            if (r_pclk && (de_o ^ pol_mask[1])) de_pix++;
        end while (!r_vs && guard < 10000);
        check(line_pix == e_line, "R2 pixels per line", line_pix, e_line);
        check(lines == e_lines, "R3 lines per frame", lines, e_lines);
        check(de_pix == e_de, "R5 enabled pixels per frame", de_pix, e_de);
        check(per_cyc == e_16, "R4 cycles per 16 pixel periods", per_cyc, e_16);
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int guard, n;
        for (int i = 0; i < 5; i++) cyc();
        rst_n = 1'b1;
        cyc();
        phase = "R1";
        check(!hsync_o && !vsync_o && !de_o && !pclk_o, "R1 strobes idle", {hsync_o, vsync_o, de_o, pclk_o}, 0);
        check(x_o == 0 && y_o == 0, "R1 coordinates", x_o + y_o, 0);

        phase = "R7";
        wr(3'd0, (32'd1 << 26) | (32'd14 << 16));
        wr(3'd1, (32'd8 << 16));
        wr(3'd2, (32'd3 << 16) | 32'd2);
        wr(3'd3, (32'd8 << 16) | 32'd4);
        wr(3'd4, (32'd1 << 22) | (32'd3 << 4) | 32'd4);
        for (int i = 0; i < 10; i++) cyc();
        check(!hsync_o && !vsync_o && !de_o && !pclk_o, "R7 idle while disabled", {hsync_o, vsync_o, de_o, pclk_o}, 0);

        phase = "R2";
        wr(3'd5, 32'd1);
        measure(15, 9, 32, 52);

        phase = "R6";
        for (int i = 0; i < 100; i++) cyc();
        wr(3'd0, (32'd1 << 26) | (32'd18 << 16));
        wr(3'd4, (32'd1 << 22) | (32'd4 << 4));
        guard = 0;
        do begin cyc(); guard++; end while (!r_hs && guard < 2000);
        n = 0;
        do begin cyc(); guard++; if (r_pclk) n++; end while (!r_hs && guard < 4000);
        check(n == 15, "R6 line length unchanged mid-frame", n, 15);
        measure(19, 9, 32, 64);

        phase = "R8";
        wr(3'd5, 32'd0);
        pol_mask = 4'hF;
        cyc();
        check(hsync_o && vsync_o && de_o && pclk_o, "R8 inverted idle levels", {hsync_o, vsync_o, de_o, pclk_o}, 15);
        wr(3'd5, 32'd1);
        measure(19, 9, 32, 64);

        phase = "R7";
        pol_mask = 4'h0;
        for (int i = 0; i < 150; i++) cyc();
        wr(3'd5, 32'd0);
        check(!hsync_o && !vsync_o && !de_o && !pclk_o && x_o == 0 && y_o == 0,
              "R7 idle one cycle after disable", {hsync_o, vsync_o, de_o, pclk_o}, 0);
        for (int i = 0; i < 5; i++) cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule